// File: doc/BRIEF.md
# Accumulator ALU with Carry, Digit Carry and Zero flags

This block is the arithmetic and logic stage of a small accumulator-based core. Operand A is always the working register. Operand B is either a value read from a file register or an immediate constant; the caller picks which one before the block sees it. The block applies one of thirteen operations: add, subtract, the three bitwise logic operations, complement, increment, decrement, clear, move, rotate through carry in either direction, and nibble swap.

It produces the result and the Carry, Digit Carry and Zero flags, with one update mask bit for each flag. Subtraction adds the two's complement of the working register to the other operand. Carry and Digit Carry therefore read as "no borrow" after a subtract. Each class of operation touches its own subset of the flags. Outputs are registered one cycle after the inputs are presented. A flag whose mask bit is clear keeps the value it last held. Where the result is written is decided outside this block.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are all zero: result, the three flags and the three update bits.
- R2: Operation code 0 (add) gives result (A+B) mod 2^W. C is the carry out of the top bit and DC is the carry out of bit W/2-1. All three update bits are set.
- R3: Operation code 1 (subtract) gives result (B−A) mod 2^W, computed as B + ~A + 1. C is 1 when B ≥ A and 0 on a borrow, so B=1, A=2 gives C=0 and B=3, A=2 gives C=1. DC is 1 when the low nibble of B is at least the low nibble of A. All three update bits are set.
- R4: Codes 2, 3 and 4 give A AND B, A OR B and A XOR B. Only the Z update bit is set.
- R5: Codes 5, 6, 7, 8 and 9 give ~B, B+1, B−1, zero and B respectively (wrapping modulo 2^W). Only the Z update bit is set, so incrementing all-ones gives zero with Z=1 and leaves C untouched.
- R6: Code 10 (rotate left) gives {B[W-2:0], carry_in} and new C = B[W-1]. Only the C update bit is set.
- R7: Code 11 (rotate right) gives {carry_in, B[W-1:1]} and new C = B[0]. Only the C update bit is set.
- R8: Code 12 (swap) exchanges the upper and lower halves of B. No update bit is set.
- R9: A flag whose update bit is clear keeps its previous output value. Codes 13 to 15 give result zero with no update bit set.
- R10: The outputs reflect the inputs sampled at the previous rising edge: one cycle of latency.
- R11: When the Z update bit is set, Z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | W | Working register operand |
| opnd_b | input | W | File register or literal operand |
| carry_in | input | 1 | Current carry, used by the rotates |
| result | output | W | Registered result |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_dc | output | 1 | Digit carry / not-digit-borrow flag |
| flag_z | output | 1 | Zero flag |
| upd_c | output | 1 | Carry was updated by the last operation |
| upd_dc | output | 1 | Digit carry was updated by the last operation |
| upd_z | output | 1 | Zero was updated by the last operation |

## Verification
The bench builds the block with the default width of 8. At that width, add and subtract are swept over every one of the 65,536 operand pairs, which reaches every carry, digit-carry and borrow boundary. Seeded random vectors over all sixteen operation codes, both carry-in values and the unused codes then exercise flag holding across mixed operation sequences. Directed cases pin the borrow examples, increment wrap-around, the rotates at their edge bits and nibble swap.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_IOR = 4'd3,
    OP_XOR = 4'd4,
    OP_COM = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_CLR = 4'd8,
    OP_MOV = 4'd9,
    OP_RLF = 4'd10,
    OP_RRF = 4'd11,
    OP_SWP = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_mask_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         dc_out
);
  localparam int H = W / 2;

  logic [W-1:0] a_x;
  logic [W:0]   full;
  logic [H:0]   low;

  // subtract: B + ~A + 1, so carries read as not-borrow
  assign a_x  = sub ? ~a_in : a_in;
  assign full = {1'b0, b_in} + {1'b0, a_x} + {{W{1'b0}}, sub};
  assign low  = {1'b0, b_in[H-1:0]} + {1'b0, a_x[H-1:0]} + {{H{1'b0}}, sub};

  assign sum    = full[W-1:0];
  assign c_out  = full[W];
  assign dc_out = low[H];
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] res
);
  localparam int H = W / 2;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = '0;
    case (op)
      OP_AND:  res = a_in & b_in;
      OP_IOR:  res = a_in | b_in;
      OP_XOR:  res = a_in ^ b_in;
      OP_COM:  res = ~b_in;
      OP_INC:  res = b_in + ONE;
      OP_DEC:  res = b_in - ONE;
      OP_CLR:  res = '0;
      OP_MOV:  res = b_in;
      OP_SWP:  res = {b_in[H-1:0], b_in[W-1:H]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int W    = 8,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  generate
    if (LEFT) begin : g_left
      assign res  = {b_in[W-2:0], cin};
      assign cout = b_in[W-1];
    end else begin : g_right
      assign res  = {cin, b_in[W-1:1]};
      assign cout = b_in[0];
    end
  endgenerate
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_BITS-1:0] op_sel,
  input  logic [W-1:0]       opnd_a,
  input  logic [W-1:0]       opnd_b,
  input  logic               carry_in,
  output logic [W-1:0]       result,
  output logic               flag_c,
  output logic               flag_dc,
  output logic               flag_z,
  output logic               upd_c,
  output logic               upd_dc,
  output logic               upd_z
);
  alu_op_e      op;
  logic [W-1:0] as_res, u_res, rl_res, rr_res, nxt_res;
  logic         as_c, as_dc, rl_c, rr_c, nxt_c, nxt_dc, nxt_z;
  flag_mask_t   nxt_m;

  assign op = alu_op_e'(op_sel);

  acc_alu_addsub #(.W(W)) u_addsub (
    .a_in(opnd_a), .b_in(opnd_b), .sub(op == OP_SUB),
    .sum(as_res), .c_out(as_c), .dc_out(as_dc)
  );

  acc_alu_unary #(.W(W)) u_unary (
    .op(op), .a_in(opnd_a), .b_in(opnd_b), .res(u_res)
  );

  acc_alu_rotate #(.W(W), .LEFT(1'b1)) u_rol (
    .b_in(opnd_b), .cin(carry_in), .res(rl_res), .cout(rl_c)
  );

  acc_alu_rotate #(.W(W), .LEFT(1'b0)) u_ror (
    .b_in(opnd_b), .cin(carry_in), .res(rr_res), .cout(rr_c)
  );

  always_comb begin
    nxt_res = '0;
    nxt_c   = 1'b0;
    nxt_dc  = 1'b0;
    nxt_m   = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res = as_res;
        nxt_c   = as_c;
        nxt_dc  = as_dc;
        nxt_m   = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC,
      OP_DEC, OP_CLR, OP_MOV: begin
        nxt_res = u_res;
        nxt_m.z = 1'b1;
      end
      OP_RLF: begin
        nxt_res = rl_res;
        nxt_c   = rl_c;
        nxt_m.c = 1'b1;
      end
      OP_RRF: begin
        nxt_res = rr_res;
        nxt_c   = rr_c;
        nxt_m.c = 1'b1;
      end
      OP_SWP: nxt_res = u_res;
      default: nxt_res = '0;
    endcase
    nxt_z = (nxt_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      flag_c  <= 1'b0;
      flag_dc <= 1'b0;
      flag_z  <= 1'b0;
      upd_c   <= 1'b0;
      upd_dc  <= 1'b0;
      upd_z   <= 1'b0;
    end else begin
      result <= nxt_res;
      upd_c  <= nxt_m.c;
      upd_dc <= nxt_m.dc;
      upd_z  <= nxt_m.z;
      if (nxt_m.c)  flag_c  <= nxt_c;
      if (nxt_m.dc) flag_dc <= nxt_dc;
      if (nxt_m.z)  flag_z  <= nxt_z;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [OP_BITS-1:0] op_sel,
  input logic [W-1:0]       opnd_a,
  input logic [W-1:0]       opnd_b,
  input logic               carry_in,
  input logic [W-1:0]       result,
  input logic               flag_c,
  input logic               flag_dc,
  input logic               flag_z,
  input logic               upd_c,
  input logic               upd_dc,
  input logic               upd_z
);
  localparam int H = W / 2;

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !flag_c && !flag_dc && !flag_z && !upd_c && !upd_dc && !upd_z));

  p_add_mask_r2: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_ADD |-> (upd_c && upd_dc && upd_z && result == $past(opnd_a) + $past(opnd_b)));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_SUB |-> (flag_c == ($past(opnd_b) >= $past(opnd_a)) && upd_c && upd_dc && upd_z));

  p_logic_mask_r4: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(op_sel) == OP_AND || $past(op_sel) == OP_IOR || $past(op_sel) == OP_XOR)
    |-> (upd_z && !upd_c && !upd_dc));

  p_rlf_r6: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_RLF |-> (result == {$past(opnd_b[W-2:0]), $past(carry_in)}
                                 && flag_c == $past(opnd_b[W-1]) && upd_c && !upd_dc && !upd_z));

  p_rrf_r7: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_RRF |-> (result == {$past(carry_in), $past(opnd_b[W-1:1])}
                                 && flag_c == $past(opnd_b[0]) && upd_c && !upd_dc && !upd_z));

  p_swap_r8: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_SWP |-> (result == {$past(opnd_b[H-1:0]), $past(opnd_b[W-1:H])}
                                 && !upd_c && !upd_dc && !upd_z));

  p_hold_c_r9: assert property (@(posedge clk) disable iff (rst || !live)
    !upd_c |-> flag_c == $past(flag_c));

  p_hold_dc_r9: assert property (@(posedge clk) disable iff (rst || !live)
    !upd_dc |-> flag_dc == $past(flag_dc));

  p_hold_z_r9: assert property (@(posedge clk) disable iff (rst || !live)
    !upd_z |-> flag_z == $past(flag_z));

  p_move_r10: assert property (@(posedge clk) disable iff (rst || !live)
    $past(op_sel) == OP_MOV |-> result == $past(opnd_b));

  p_zflag_r11: assert property (@(posedge clk) disable iff (rst || !live)
    upd_z |-> flag_z == (result == '0));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .carry_in(carry_in), .result(result), .flag_c(flag_c), .flag_dc(flag_dc),
  .flag_z(flag_z), .upd_c(upd_c), .upd_dc(upd_dc), .upd_z(upd_z)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       flag_c, flag_dc, flag_z, upd_c, upd_dc, upd_z;

  int n_chk = 0;
  int n_bad = 0;
  logic e_c = 1'b0, e_dc = 1'b0, e_z = 1'b0;

  always #5 clk = ~clk;

  acc_alu #(.W(8)) u_acc_alu (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .result(result), .flag_c(flag_c), .flag_dc(flag_dc),
    .flag_z(flag_z), .upd_c(upd_c), .upd_dc(upd_dc), .upd_z(upd_z)
  );

  task automatic compare(input string tag, input logic [13:0] exp_v);
    logic [13:0] got_v;
    got_v = {result, flag_c, flag_dc, flag_z, upd_c, upd_dc, upd_z};
    n_chk++;
    if (got_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%b: got %h exp %h",
               tag, op_sel, opnd_a, opnd_b, carry_in, got_v, exp_v);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic ci, input string note);
    logic [8:0] s;
    logic [7:0] r;
    logic       c, dc, mc, mdc, mz;
    string      tag;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
    r = '0; c = 1'b0; dc = 1'b0; mc = 1'b0; mdc = 1'b0; mz = 1'b0;
    case (op)
      4'd0: begin
        s = {1'b0, a} + {1'b0, b}; r = s[7:0]; c = s[8];
        dc = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        mc = 1'b1; mdc = 1'b1; mz = 1'b1; tag = "R2";
      end
      4'd1: begin
        r = b - a; c = (b >= a); dc = (b[3:0] >= a[3:0]);
        mc = 1'b1; mdc = 1'b1; mz = 1'b1; tag = "R3";
      end
      4'd2: begin r = a & b; mz = 1'b1; tag = "R4"; end
      4'd3: begin r = a | b; mz = 1'b1; tag = "R4"; end
      4'd4: begin r = a ^ b; mz = 1'b1; tag = "R4"; end
      4'd5: begin r = ~b; mz = 1'b1; tag = "R5"; end
      4'd6: begin r = b + 8'd1; mz = 1'b1; tag = "R5"; end
      4'd7: begin r = b - 8'd1; mz = 1'b1; tag = "R5"; end
      4'd8: begin r = 8'd0; mz = 1'b1; tag = "R5"; end
      4'd9: begin r = b; mz = 1'b1; tag = "R5"; end
      4'd10: begin r = {b[6:0], ci}; c = b[7]; mc = 1'b1; tag = "R6"; end
      4'd11: begin r = {ci, b[7:1]}; c = b[0]; mc = 1'b1; tag = "R7"; end
      4'd12: begin r = {b[3:0], b[7:4]}; tag = "R8"; end
      default: begin r = 8'd0; tag = "R9"; end
    endcase
    if (mc)  e_c  = c;
    if (mdc) e_dc = dc;
    if (mz)  e_z  = (r == 8'd0);
    @(posedge clk);
    #1;
    compare({tag, note}, {r, e_c, e_dc, e_z, mc, mdc, mz});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired: got running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset holds outputs at zero even with live inputs
    op_sel = 4'd0; opnd_a = 8'hFF; opnd_b = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset", 14'd0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    step(4'd0, 8'hFF, 8'h01, 1'b0, " add wrap");          // R2: 00, C=1 DC=1 Z=1
    step(4'd0, 8'h08, 8'h08, 1'b0, " add digit carry");   // R2
    step(4'd1, 8'h02, 8'h01, 1'b0, " 1-2 borrow");        // R3: C=0
    step(4'd1, 8'h02, 8'h03, 1'b0, " 3-2 no borrow");     // R3: C=1
    step(4'd1, 8'h5A, 8'h5A, 1'b0, " equal");             // R3: Z=1 C=1
    step(4'd2, 8'h0F, 8'hF0, 1'b0, " R9 carry held");     // R4 zero result
    step(4'd6, 8'h00, 8'hFF, 1'b0, " inc wrap");          // R5
    step(4'd7, 8'h00, 8'h00, 1'b0, " dec wrap");          // R5
    step(4'd10, 8'h00, 8'h80, 1'b0, " rol edge");         // R6
    step(4'd11, 8'h00, 8'h01, 1'b1, " ror edge");         // R7
    step(4'd12, 8'h00, 8'hA5, 1'b0, " swap");             // R8
    step(4'd13, 8'h33, 8'h44, 1'b1, " unused code");      // R9
    step(4'd9, 8'h00, 8'h3C, 1'b0, " R10 move latency");  // R10
    step(4'd8, 8'h12, 8'h34, 1'b0, " R11 clear zero");    // R11

    // exhaustive add and subtract
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        step(4'd0, 8'(i), 8'(j), 1'b0, " sweep");
        step(4'd1, 8'(i), 8'(j), 1'b0, " sweep");
      end
    end

    // random mix over every code
    for (int k = 0; k < 30000; k++) begin
      step(4'($urandom_range(15, 0)), 8'($urandom), 8'($urandom),
           1'($urandom), " random R11");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule